// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the interrupt conditions of one UART channel and holds each as a pending flag. It ranks the enabled flags and presents the winner as a 6-bit identification code. A single interrupt line is raised while any enabled flag is pending. Conditions come in as one-cycle event pulses, with two exceptions: a level that reports errored characters still waiting in the receive FIFO, and the two active-low flow-control pins. Register-access strobes retire the flags. Each source has its own clear rule, so a read of one register never disturbs a source that belongs to another register.

The identification code is decoded from the registered flags, so it changes in the cycle after the event or strobe that caused the change. The interrupt line has one more register stage. The shifters, FIFOs and baud logic sit outside the block. The flow pins are assumed to be already synchronous to `clk`.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset `id_code` reads 6'b000001 (bit 0 high means nothing pending) and `irq` is low.
- R2: Source codes are: line error 6'b000110, RX timeout 6'b001100, RX data 6'b000100, TX empty 6'b000010, modem change 6'b000000, Xoff/special character 6'b010000, flow pin change 6'b100000. No other value ever appears.
- R3: Ranking from highest to lowest is: line error, RX timeout, RX data, TX empty, modem change, Xoff/special, flow pin. RX timeout wins over RX data when both are pending.
- R4: An overrun pulse sets a line-error flag that only an LSR read clears. The FIFO-error level keeps a line error pending for as long as it stays high.
- R5: RX timeout and RX data flags are cleared by a receive-register read.
- R6: The TX flag is cleared by a transmit-register write, or by an identification read in a cycle where TX is the code shown.
- R7: The modem flag is cleared only by an MSR read. An identification read leaves it pending.
- R8: An Xoff character sets a flag that is cleared only by an Xon character. A special character sets a flag that is cleared by an identification read while code 6'b010000 is shown.
- R9: A low-to-high transition on `cts_n` or `rts_n` sets the flow flag, and a high-to-low transition does not. The flag is cleared by an identification read while it is shown.
- R10: An identification read clears only the source currently shown. The next pending source is shown in the following cycle.
- R11: `int_en` bit 0 covers RX timeout and RX data, bit 1 TX, bit 2 line error, bit 3 modem, bit 4 Xoff/special and bit 5 the flow pins. An event whose bit is low is not latched. A pending flag whose bit is low is neither shown nor signalled, and with `int_en` all zero `id_code` reads 6'b000001.
- R12: When a set event and a clear strobe hit the same flag in one cycle, the flag ends up set.
- R13: `irq` is high in a cycle exactly when, one cycle earlier, `id_code` showed a pending source under the enables now applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 6 | Per-source-type enables (mapping in R11) |
| ovr_evt | input | 1 | Overrun occurred (pulse) |
| err_in_fifo | input | 1 | Framing/parity/break character present in RX FIFO (level) |
| tout_evt | input | 1 | RX timeout detected (pulse) |
| rxd_evt | input | 1 | RX data ready / trigger reached (pulse) |
| txe_evt | input | 1 | TX holding empty / trigger reached (pulse) |
| msc_evt | input | 1 | Modem input changed (pulse) |
| xoff_evt | input | 1 | Xoff character received (pulse) |
| xon_evt | input | 1 | Xon character received (pulse) |
| spec_evt | input | 1 | Special character received (pulse) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | input | 1 | Request-to-send pin, active low |
| id_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rhr_rd | input | 1 | Receive register read strobe |
| thr_wr | input | 1 | Transmit register write strobe |
| id_code | output | 6 | Identification code of the highest enabled pending source |
| irq | output | 1 | Registered interrupt request |

## Verification
The setting of a flag and the clearing of that same flag can land in one cycle. This happens when a TX-empty pulse coincides with a transmit write, or with an identification read that retires TX. It also happens with a receive pulse and a receive read, or with Xoff and Xon characters. The bench drives both in a single cycle and expects the flag to stay pending, with the same code in the next sample. A second kind of collision is an identification read that retires the shown source while a lower one is waiting. Here the bench expects the lower code in the very next sample.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int CODE_W = 6;
  localparam int EN_W   = 6;
  localparam int NSRC   = 7;
  localparam int NFLG   = 9;

  // source slots, in rank order (slot 0 ranks highest)
  localparam int S_LINE = 0;
  localparam int S_TOUT = 1;
  localparam int S_RXD  = 2;
  localparam int S_TX   = 3;
  localparam int S_MDM  = 4;
  localparam int S_XF   = 5;
  localparam int S_FLOW = 6;

  // enable bit positions
  localparam int E_RX   = 0;
  localparam int E_TX   = 1;
  localparam int E_LINE = 2;
  localparam int E_MDM  = 3;
  localparam int E_XF   = 4;
  localparam int E_FLOW = 5;

  // latched flag slots
  localparam int F_OVR  = 0;
  localparam int F_ERR  = 1;
  localparam int F_TOUT = 2;
  localparam int F_RXD  = 3;
  localparam int F_TX   = 4;
  localparam int F_MDM  = 5;
  localparam int F_XCHR = 6;
  localparam int F_SPEC = 7;
  localparam int F_FLOW = 8;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

  typedef struct packed {
    logic ovr;
    logic tout;
    logic rxd;
    logic txe;
    logic msc;
    logic xoff;
    logic xon;
    logic spec;
  } evt_t;

  typedef struct packed {
    logic id_rd;
    logic lsr_rd;
    logic msr_rd;
    logic rhr_rd;
    logic thr_wr;
  } strobe_t;

  function automatic logic [CODE_W-1:0] src_code(input int slot);
    logic [CODE_W-1:0] c;
    case (slot)
      S_LINE:  c = 6'b000110;
      S_TOUT:  c = 6'b001100;
      S_RXD:   c = 6'b000100;
      S_TX:    c = 6'b000010;
      S_MDM:   c = 6'b000000;
      S_XF:    c = 6'b010000;
      S_FLOW:  c = 6'b100000;
      default: c = CODE_IDLE;
    endcase
    return c;
  endfunction

  function automatic int src_en_bit(input int slot);
    int b;
    case (slot)
      S_LINE:         b = E_LINE;
      S_TOUT, S_RXD:  b = E_RX;
      S_TX:           b = E_TX;
      S_MDM:          b = E_MDM;
      S_XF:           b = E_XF;
      default:        b = E_FLOW;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/uart_irq_pin_edge.sv
module uart_irq_pin_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_n,
  output logic             rise_any
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic prev_ld;

    always_comb begin
      rise[i]  = pins_n[i] & ~prev_q[i];
      prev_ld  = pins_n[i] ^ prev_q[i];
    end

    // reset to the inactive level so a pin held high is not seen as an edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b1;
      end else if (prev_ld) begin
        prev_q[i] <= pins_n[i];
      end
    end
  end

  assign rise_any = |rise;

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] int_en,
  input  evt_t            evt,
  input  strobe_t         stb,
  input  logic            err_lvl,
  input  logic            flow_rise,
  input  logic [NSRC-1:0] shown,
  output logic [NSRC-1:0] pend
);

  logic [NFLG-1:0] flg_q;
  logic [NFLG-1:0] set;
  logic [NFLG-1:0] clr;

  // next-state terms: set and clear per flag
  always_comb begin
    set[F_OVR]  = evt.ovr   & int_en[E_LINE];
    clr[F_OVR]  = stb.lsr_rd;
    set[F_ERR]  = err_lvl   & int_en[E_LINE];
    clr[F_ERR]  = ~err_lvl;
    set[F_TOUT] = evt.tout  & int_en[E_RX];
    clr[F_TOUT] = stb.rhr_rd;
    set[F_RXD]  = evt.rxd   & int_en[E_RX];
    clr[F_RXD]  = stb.rhr_rd;
    set[F_TX]   = evt.txe   & int_en[E_TX];
    clr[F_TX]   = stb.thr_wr | (stb.id_rd & shown[S_TX]);
    set[F_MDM]  = evt.msc   & int_en[E_MDM];
    clr[F_MDM]  = stb.msr_rd;
    set[F_XCHR] = evt.xoff  & int_en[E_XF];
    clr[F_XCHR] = evt.xon;
    set[F_SPEC] = evt.spec  & int_en[E_XF];
    clr[F_SPEC] = stb.id_rd & shown[S_XF];
    set[F_FLOW] = flow_rise & int_en[E_FLOW];
    clr[F_FLOW] = stb.id_rd & shown[S_FLOW];
  end

  // one register per flag; load on set or clear, set taking precedence
  for (genvar f = 0; f < NFLG; f++) begin : g_flag
    logic ld;
    assign ld = set[f] | clr[f];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q[f] <= 1'b0;
      end else if (ld) begin
        flg_q[f] <= set[f];
      end
    end
  end

  always_comb begin
    pend[S_LINE] = flg_q[F_OVR] | flg_q[F_ERR];
    pend[S_TOUT] = flg_q[F_TOUT];
    pend[S_RXD]  = flg_q[F_RXD];
    pend[S_TX]   = flg_q[F_TX];
    pend[S_MDM]  = flg_q[F_MDM];
    pend[S_XF]   = flg_q[F_XCHR] | flg_q[F_SPEC];
    pend[S_FLOW] = flg_q[F_FLOW];
  end

endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0]   pend,
  input  logic [EN_W-1:0]   int_en,
  output logic [NSRC-1:0]   shown,
  output logic [CODE_W-1:0] code,
  output logic              any
);

  logic [NSRC-1:0] masked;

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    localparam int EB = src_en_bit(i);
    assign masked[i] = pend[i] & int_en[EB];
  end

  // first enabled pending slot in rank order wins
  always_comb begin
    logic hit;
    hit   = 1'b0;
    shown = '0;
    code  = CODE_IDLE;
    for (int i = 0; i < NSRC; i++) begin
      if (masked[i] && !hit) begin
        hit      = 1'b1;
        shown[i] = 1'b1;
        code     = src_code(i);
      end
    end
  end

  assign any = |masked;

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int FLOW_PINS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EN_W-1:0]   int_en,
  input  logic              ovr_evt,
  input  logic              err_in_fifo,
  input  logic              tout_evt,
  input  logic              rxd_evt,
  input  logic              txe_evt,
  input  logic              msc_evt,
  input  logic              xoff_evt,
  input  logic              xon_evt,
  input  logic              spec_evt,
  input  logic              cts_n,
  input  logic              rts_n,
  input  logic              id_rd,
  input  logic              lsr_rd,
  input  logic              msr_rd,
  input  logic              rhr_rd,
  input  logic              thr_wr,
  output logic [CODE_W-1:0] id_code,
  output logic              irq
);

  evt_t                evt;
  strobe_t             stb;
  logic [FLOW_PINS-1:0] pins_n;
  logic                flow_rise;
  logic [NSRC-1:0]     pend;
  logic [NSRC-1:0]     shown;
  logic                any_pend;
  logic                irq_q;
  logic                irq_d;
  logic                irq_ld;

  always_comb begin
    evt.ovr    = ovr_evt;
    evt.tout   = tout_evt;
    evt.rxd    = rxd_evt;
    evt.txe    = txe_evt;
    evt.msc    = msc_evt;
    evt.xoff   = xoff_evt;
    evt.xon    = xon_evt;
    evt.spec   = spec_evt;
    stb.id_rd  = id_rd;
    stb.lsr_rd = lsr_rd;
    stb.msr_rd = msr_rd;
    stb.rhr_rd = rhr_rd;
    stb.thr_wr = thr_wr;
  end

  if (FLOW_PINS == 2) begin : g_pins_two
    assign pins_n = {rts_n, cts_n};
  end else begin : g_pins_cts
    assign pins_n = {FLOW_PINS{cts_n & rts_n}};
  end

  uart_irq_pin_edge #(
    .WIDTH (FLOW_PINS)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_n   (pins_n),
    .rise_any (flow_rise)
  );

  uart_irq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_en    (int_en),
    .evt       (evt),
    .stb       (stb),
    .err_lvl   (err_in_fifo),
    .flow_rise (flow_rise),
    .shown     (shown),
    .pend      (pend)
  );

  uart_irq_rank u_rank (
    .pend   (pend),
    .int_en (int_en),
    .shown  (shown),
    .code   (id_code),
    .any    (any_pend)
  );

  always_comb begin
    irq_d  = any_pend;
    irq_ld = irq_d ^ irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ld) begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] int_en,
  input logic [5:0] id_code,
  input logic       irq,
  input logic       id_rd,
  input logic       msr_rd,
  input logic       rhr_rd,
  input logic       thr_wr,
  input logic       rxd_evt,
  input logic       tout_evt,
  input logic       txe_evt,
  input logic       msc_evt,
  input logic       flow_rise
);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    id_code inside {6'b000001, 6'b000110, 6'b001100, 6'b000100,
                    6'b000010, 6'b000000, 6'b010000, 6'b100000});

  assert_irq_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(id_code != 6'b000001));

  assert_rhr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !rxd_evt && !tout_evt) |=> (id_code != 6'b000100 && id_code != 6'b001100));

  assert_thr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txe_evt) |=> (id_code != 6'b000010));

  assert_msr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !msc_evt) |=> (id_code != 6'b000000));

  assert_id_read_flow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id_code == 6'b100000 && !flow_rise) |=> (id_code != 6'b100000));

  assert_all_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 6'b000000) |-> (id_code == 6'b000001));

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_en    (int_en),
  .id_code   (id_code),
  .irq       (irq),
  .id_rd     (id_rd),
  .msr_rd    (msr_rd),
  .rhr_rd    (rhr_rd),
  .thr_wr    (thr_wr),
  .rxd_evt   (rxd_evt),
  .tout_evt  (tout_evt),
  .txe_evt   (txe_evt),
  .msc_evt   (msc_evt),
  .flow_rise (flow_rise)
);

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;

  localparam logic [12:0] P_NONE  = 13'h0000;
  localparam logic [12:0] P_OVR   = 13'h0001;
  localparam logic [12:0] P_TOUT  = 13'h0002;
  localparam logic [12:0] P_RXD   = 13'h0004;
  localparam logic [12:0] P_TXE   = 13'h0008;
  localparam logic [12:0] P_MSC   = 13'h0010;
  localparam logic [12:0] P_XOFF  = 13'h0020;
  localparam logic [12:0] P_XON   = 13'h0040;
  localparam logic [12:0] P_SPEC  = 13'h0080;
  localparam logic [12:0] P_IDRD  = 13'h0100;
  localparam logic [12:0] P_LSRRD = 13'h0200;
  localparam logic [12:0] P_MSRRD = 13'h0400;
  localparam logic [12:0] P_RHRRD = 13'h0800;
  localparam logic [12:0] P_THRWR = 13'h1000;

  localparam logic [5:0] C_IDLE = 6'b000001;
  localparam logic [5:0] C_LINE = 6'b000110;
  localparam logic [5:0] C_TOUT = 6'b001100;
  localparam logic [5:0] C_RXD  = 6'b000100;
  localparam logic [5:0] C_TX   = 6'b000010;
  localparam logic [5:0] C_MDM  = 6'b000000;
  localparam logic [5:0] C_XF   = 6'b010000;
  localparam logic [5:0] C_FLOW = 6'b100000;

  logic        clk;
  logic        rst_n;
  logic [5:0]  int_en;
  logic [12:0] pulse;
  logic        err_in_fifo;
  logic        cts_n;
  logic        rts_n;
  logic [5:0]  id_code;
  logic        irq;

  logic [5:0]  en_tb;
  logic        err_tb;
  logic        cts_tb;
  logic        rts_tb;
  logic [5:0]  prev_code;

  logic [5:0]  q_code[$];
  logic        q_irq[$];
  string       q_req[$];

  int n_chk;
  int n_bad;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  uart_irq_arbiter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_en      (int_en),
    .ovr_evt     (pulse[0]),
    .err_in_fifo (err_in_fifo),
    .tout_evt    (pulse[1]),
    .rxd_evt     (pulse[2]),
    .txe_evt     (pulse[3]),
    .msc_evt     (pulse[4]),
    .xoff_evt    (pulse[5]),
    .xon_evt     (pulse[6]),
    .spec_evt    (pulse[7]),
    .cts_n       (cts_n),
    .rts_n       (rts_n),
    .id_rd       (pulse[8]),
    .lsr_rd      (pulse[9]),
    .msr_rd      (pulse[10]),
    .rhr_rd      (pulse[11]),
    .thr_wr      (pulse[12]),
    .id_code     (id_code),
    .irq         (irq)
  );

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  task automatic compare(input string req, input logic [5:0] ec, input logic ei);
    n_chk++;
    if (id_code !== ec || irq !== ei) begin
      n_bad++;
      $display("FAIL %s: id_code=%b irq=%b expected id_code=%b irq=%b",
               req, id_code, irq, ec, ei);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the next edge
  // irq_x < 0: expected irq is "a source was shown one sample earlier"
  task automatic step(input logic [12:0] p, input logic [5:0] ec,
                      input int irq_x, input string req);
    @(negedge clk);
    pulse       = p;
    int_en      = en_tb;
    err_in_fifo = err_tb;
    cts_n       = cts_tb;
    rts_n       = rts_tb;
    q_code.push_back(ec);
    q_irq.push_back((irq_x < 0) ? (prev_code != C_IDLE) : (irq_x != 0));
    q_req.push_back(req);
    prev_code = ec;
  endtask

  // monitor: samples 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q_code.size() != 0) begin
        logic [5:0] ec;
        logic       ei;
        string      rq;
        ec = q_code.pop_front();
        ei = q_irq.pop_front();
        rq = q_req.pop_front();
        compare(rq, ec, ei);
      end
    end
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    prev_code = C_IDLE;
    rst_n = 1'b0;
    pulse = P_NONE;
    en_tb = 6'h3F;
    err_tb = 1'b0;
    cts_tb = 1'b1;
    rts_tb = 1'b1;
    int_en = en_tb;
    err_in_fifo = 1'b0;
    cts_n = 1'b1;
    rts_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    compare("R1 in reset", C_IDLE, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    step(P_NONE, C_IDLE, -1, "R1 after reset");

    // R6 TX set, cleared by transmit write
    step(P_TXE,   C_TX,   -1, "R2 R6 tx set");
    step(P_NONE,  C_TX,   -1, "R13 irq high");
    step(P_THRWR, C_IDLE, -1, "R6 thr write clears");
    step(P_NONE,  C_IDLE, -1, "R13 irq low");

    // R3 ranking
    step(P_RXD | P_TXE | P_MSC, C_RXD, -1, "R3 rx over tx and modem");
    step(P_TOUT,  C_TOUT, -1, "R3 timeout over rx data");
    step(P_RHRRD, C_TX,   -1, "R5 rhr read clears both rx");
    step(P_IDRD,  C_MDM,  -1, "R6 R10 id read retires tx");
    step(P_IDRD,  C_MDM,  -1, "R7 id read keeps modem");
    step(P_MSRRD, C_IDLE, -1, "R7 msr read clears");

    // R4 overrun and FIFO error level
    step(P_OVR | P_RXD, C_LINE, -1, "R4 overrun ranks first");
    step(P_LSRRD, C_RXD,  -1, "R4 lsr read clears overrun");
    step(P_RHRRD, C_IDLE, -1, "R5 rhr read");
    err_tb = 1'b1;
    step(P_OVR,   C_LINE, -1, "R4 error level");
    step(P_LSRRD, C_LINE, -1, "R4 level holds past lsr read");
    step(P_RHRRD, C_LINE, -1, "R4 level holds past rhr read");
    err_tb = 1'b0;
    step(P_NONE,  C_IDLE, -1, "R4 level gone");

    // R8 Xoff / special
    step(P_XOFF,  C_XF,   -1, "R8 xoff set");
    step(P_IDRD,  C_XF,   -1, "R8 id read ignores xoff char");
    step(P_XON,   C_IDLE, -1, "R8 xon clears");
    step(P_SPEC,  C_XF,   -1, "R8 special set");
    step(P_IDRD,  C_IDLE, -1, "R8 id read clears special");
    step(P_XOFF | P_SPEC, C_XF, -1, "R8 both causes");
    step(P_XON,   C_XF,   -1, "R8 special survives xon");
    step(P_IDRD,  C_IDLE, -1, "R8 id read clears rest");

    // R9 flow pins
    cts_tb = 1'b0;
    step(P_NONE,  C_IDLE, -1, "R9 cts falling ignored");
    cts_tb = 1'b1;
    step(P_NONE,  C_FLOW, -1, "R9 cts rising");
    step(P_IDRD,  C_IDLE, -1, "R9 id read clears");
    rts_tb = 1'b0;
    step(P_NONE,  C_IDLE, -1, "R9 rts falling ignored");
    rts_tb = 1'b1;
    step(P_NONE,  C_FLOW, -1, "R9 rts rising");
    step(P_MSRRD, C_FLOW, -1, "R9 msr read no effect");
    step(P_IDRD,  C_IDLE, -1, "R9 id read clears rts");

    // R10 id read only retires the shown source
    cts_tb = 1'b0;
    step(P_NONE,  C_IDLE, -1, "R10 prep");
    cts_tb = 1'b1;
    step(P_TXE,   C_TX,   -1, "R10 tx over flow");
    step(P_IDRD,  C_FLOW, -1, "R10 flow appears next");
    step(P_IDRD,  C_IDLE, -1, "R10 flow cleared");

    // R12 set beats clear in the same cycle
    step(P_TXE | P_THRWR, C_TX, -1, "R12 tx set with thr write");
    step(P_TXE | P_IDRD,  C_TX, -1, "R12 tx set with id read");
    step(P_IDRD,  C_IDLE, -1, "R12 tx clear");
    step(P_RXD | P_RHRRD, C_RXD, -1, "R12 rx set with rhr read");
    step(P_RHRRD, C_IDLE, -1, "R12 rx clear");
    step(P_XOFF | P_XON,  C_XF, -1, "R12 xoff with xon");
    step(P_XON,   C_IDLE, -1, "R12 xoff clear");

    // R11 enables
    en_tb = 6'h00;
    step(P_TXE | P_OVR | P_SPEC, C_IDLE, -1, "R11 disabled not latched");
    en_tb = 6'h3F;
    step(P_NONE,  C_IDLE, -1, "R11 nothing kept");
    en_tb = 6'h3B;
    step(P_OVR | P_TXE, C_TX, -1, "R11 line bit off");
    en_tb = 6'h3F;
    step(P_THRWR, C_IDLE, -1, "R11 overrun never latched");
    step(P_MSC,   C_MDM,  -1, "R11 modem set");
    step(P_NONE,  C_MDM,  -1, "R13 modem irq");
    en_tb = 6'h37;
    step(P_NONE,  C_IDLE, 0,  "R11 modem masked");
    en_tb = 6'h3F;
    step(P_NONE,  C_MDM,  1,  "R11 modem unmasked");
    step(P_MSRRD, C_IDLE, -1, "R7 msr read");
    step(P_NONE,  C_IDLE, -1, "R13 final");

    wait (q_code.size() == 0);
    repeat (2) @(posedge clk);
    report();
    $finish;
  end

endmodule